// File: doc/BRIEF.md
# Edge Timestamp Ring Buffer with Coalesced Interrupt

This block collects edge events from a five-channel time-measurement front end and keeps the most recent 256 of them in a circular memory. Each channel presents a valid strobe together with a coarse count, a fine count and an edge polarity. A single global enable gates all five channels at once. Every accepted event is tagged with its channel number and edge type, then written into the ring. When the ring is full, the oldest entry is dropped and a sticky overflow flag is raised.

The host drains the ring by popping the oldest unread entry. It can also watch the write pointer and a wrap counter to tell which slots are new. To keep the host interrupt load low, the block raises one interrupt line on either of two conditions. The first is that the unread count has reached a programmable threshold. The second is that a programmable number of cycles has passed while entries were still waiting. Each source has its own enable. Status bits are cleared by writing ones.

Top module: `tstamp_ring`

## Requirements
- R1: While `en` is low, events on every channel are ignored: `unread_cnt`, `wr_ptr` and the ring contents do not change.
- R2: A stored entry is 53 bits wide. Bits [52:21] hold the coarse count, bits [20:4] the fine count, bits [3:1] the channel number (0 to 4) and bit 0 the edge flag (1 = rising).
- R3: An event accepted at a clock edge is written one edge later. Events accepted in the same cycle are written one per cycle in ascending channel order, so `unread_cnt` rises by at most one per cycle. A single channel can deliver one event every cycle.
- R4: A pop (`rd_pop` high) with at least one unread entry returns the oldest unread entry on `rd_data`, with `rd_valid` high in the next cycle. A pop with no unread entry is ignored and leaves `rd_valid` low.
- R5: The ring holds 256 entries. A write into a full ring with no pop in the same cycle discards the oldest entry, keeps `unread_cnt` at 256 and sets overflow status bit 2.
- R6: `wr_ptr` advances by one, modulo 256, for every stored entry. `wrap_cnt` increments each time `wr_ptr` goes from 255 back to 0.
- R7: Status bit 0 is set in the cycle after `cfg_cnt_en` is high, `cfg_cnt_thr` is non-zero and `unread_cnt` is at or above `cfg_cnt_thr`.
- R8: An idle timer is held at zero while the ring is empty or in any cycle that sets bit 0 or bit 1. In every other cycle it counts up by one. Status bit 1 is set when `cfg_tmo_en` is high, `cfg_tmo` is non-zero, entries are unread and the timer has reached `cfg_tmo`.
- R9: Writing a one to an `irq_ack` bit clears the matching status bit. A set condition in the same cycle wins over the clear. The overflow bit stays set until it is acknowledged.
- R10: `irq` is high exactly when status bit 0 or bit 1 is set. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable for all channels |
| ev_valid | input | 5 | Per-channel event strobe |
| ev_rising | input | 5 | Per-channel edge polarity (1 = rising) |
| ev_coarse | input | 160 | Coarse counts, channel i at [32i+31:32i] |
| ev_fine | input | 85 | Fine counts, channel i at [17i+16:17i] |
| rd_pop | input | 1 | Pop the oldest unread entry |
| rd_valid | output | 1 | `rd_data` holds a popped entry |
| rd_data | output | 53 | Popped entry |
| unread_cnt | output | 9 | Number of unread entries (0 to 256) |
| wr_ptr | output | 8 | Next ring slot to be written |
| wrap_cnt | output | 16 | Number of write-pointer wraps |
| cfg_cnt_en | input | 1 | Enable for the count interrupt |
| cfg_tmo_en | input | 1 | Enable for the timeout interrupt |
| cfg_cnt_thr | input | 9 | Unread-count threshold |
| cfg_tmo | input | 16 | Idle timeout in cycles |
| irq_ack | input | 3 | Write-one-to-clear for the status bits |
| irq_status | output | 3 | Bit 0 count, bit 1 timeout, bit 2 overflow |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The unread count never exceeds the depth and never rises by more than one per cycle. The write pointer only ever steps by one. A returned entry always follows a non-empty ring. A count or timeout status bit only rises under its own condition, and overflow stays set until it is acknowledged.

Other behaviour can only be shown by the bench scenarios, compared against a queue-based model on every clock. These are the order in which simultaneous channels are written, the exact entry that survives an overwrite, the number of cycles until a timeout fires, and the outcome of an acknowledge that meets a condition still being true.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int COARSE_W = 32;
    localparam int FINE_W   = 17;
    localparam int CH_W     = 3;

    // status bit positions
    localparam int ST_CNT = 0;
    localparam int ST_TMO = 1;
    localparam int ST_OVF = 2;
    localparam int ST_W   = 3;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic [CH_W-1:0]     chan;
        logic                rising;
    } tstamp_t;

    localparam int ENT_W = $bits(tstamp_t);

    function automatic tstamp_t make_stamp(input logic [COARSE_W-1:0] coarse,
                                           input logic [FINE_W-1:0]   fine,
                                           input logic [CH_W-1:0]     chan,
                                           input logic                rising);
        tstamp_t s;
        s.coarse = coarse;
        s.fine   = fine;
        s.chan   = chan;
        s.rising = rising;
        return s;
    endfunction

endpackage

// File: rtl/tsr_capture.sv
module tsr_capture import tsr_pkg::*; #(
    parameter int NUM_CH = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [NUM_CH-1:0]          ev_valid,
    input  logic [NUM_CH-1:0]          ev_rising,
    input  logic [NUM_CH*COARSE_W-1:0] ev_coarse,
    input  logic [NUM_CH*FINE_W-1:0]   ev_fine,
    output logic                       wr_vld,
    output tstamp_t                    wr_ent
);

    logic [NUM_CH-1:0] full_q;
    logic [NUM_CH-1:0] grant;
    tstamp_t           hold_q [NUM_CH];

    // lowest-numbered waiting channel wins the single write slot
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (full_q[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    always_comb begin
        wr_ent = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) wr_ent = hold_q[i];
        end
    end

    assign wr_vld = |grant;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic    full_r;
        tstamp_t hold_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                full_r <= 1'b0;
                hold_r <= '0;
            end else if (en && ev_valid[g] && (!full_r || grant[g])) begin
                full_r <= 1'b1;
                hold_r <= make_stamp(ev_coarse[g*COARSE_W +: COARSE_W],
                                     ev_fine[g*FINE_W +: FINE_W],
                                     CH_W'(g), ev_rising[g]);
            end else if (grant[g]) begin
                full_r <= 1'b0;
            end
        end

        assign full_q[g] = full_r;
        assign hold_q[g] = hold_r;
    end

endmodule

// File: rtl/tsr_ring.sv
module tsr_ring import tsr_pkg::*; #(
    parameter int DEPTH  = 256,
    parameter int WRAP_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  tstamp_t           wr_ent,
    input  logic              pop,
    output logic              rd_valid,
    output tstamp_t           rd_data,
    output logic [CW-1:0]     unread_cnt,
    output logic [AW-1:0]     wr_ptr,
    output logic [WRAP_W-1:0] wrap_cnt,
    output logic              ovf_evt
);

    tstamp_t       mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          pop_ok, full, grow;

    assign pop_ok  = pop && (cnt_q != '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign ovf_evt = wr_vld && full && !pop_ok;
    assign grow    = wr_vld && !ovf_evt;

    always_ff @(posedge clk) begin
        if (wr_vld) mem[wp_q] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= '0;
            rp_q     <= '0;
            cnt_q    <= '0;
            wrap_cnt <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pop_ok;
            if (pop_ok) rd_data <= mem[rp_q];
            if (wr_vld) begin
                wp_q <= wp_q + 1'b1;
                if (wp_q == AW'(DEPTH - 1)) wrap_cnt <= wrap_cnt + 1'b1;
            end
            if (pop_ok || ovf_evt) rp_q <= rp_q + 1'b1;
            if (grow && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (!grow && pop_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign unread_cnt = cnt_q;
    assign wr_ptr     = wp_q;

endmodule

// File: rtl/tsr_irq.sv
module tsr_irq import tsr_pkg::*; #(
    parameter int CW    = 9,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    unread_cnt,
    input  logic             cfg_cnt_en,
    input  logic             cfg_tmo_en,
    input  logic [CW-1:0]    cfg_cnt_thr,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic [ST_W-1:0]  irq_ack,
    input  logic             ovf_evt,
    output logic [ST_W-1:0]  irq_status,
    output logic             irq
);

    logic [TMO_W-1:0] timer_q;
    logic             pending, fire_cnt, fire_tmo;
    logic [ST_W-1:0]  set_vec;

    assign pending  = (unread_cnt != '0);
    assign fire_cnt = cfg_cnt_en && (cfg_cnt_thr != '0) && (unread_cnt >= cfg_cnt_thr);
    assign fire_tmo = cfg_tmo_en && (cfg_tmo != '0) && pending && (timer_q >= cfg_tmo);

    always_comb begin
        set_vec         = '0;
        set_vec[ST_CNT] = fire_cnt;
        set_vec[ST_TMO] = fire_tmo;
        set_vec[ST_OVF] = ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q    <= '0;
            irq_status <= '0;
        end else begin
            timer_q    <= (!pending || fire_cnt || fire_tmo) ? '0 : timer_q + 1'b1;
            irq_status <= (irq_status & ~irq_ack) | set_vec;
        end
    end

    assign irq = irq_status[ST_CNT] | irq_status[ST_TMO];

endmodule

// File: rtl/tstamp_ring.sv
module tstamp_ring import tsr_pkg::*; #(
    parameter int NUM_CH = 5,
    parameter int DEPTH  = 256,
    parameter int TMO_W  = 16,
    parameter int WRAP_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [NUM_CH-1:0]          ev_valid,
    input  logic [NUM_CH-1:0]          ev_rising,
    input  logic [NUM_CH*COARSE_W-1:0] ev_coarse,
    input  logic [NUM_CH*FINE_W-1:0]   ev_fine,
    input  logic                       rd_pop,
    output logic                       rd_valid,
    output logic [ENT_W-1:0]           rd_data,
    output logic [CW-1:0]              unread_cnt,
    output logic [AW-1:0]              wr_ptr,
    output logic [WRAP_W-1:0]          wrap_cnt,
    input  logic                       cfg_cnt_en,
    input  logic                       cfg_tmo_en,
    input  logic [CW-1:0]              cfg_cnt_thr,
    input  logic [TMO_W-1:0]           cfg_tmo,
    input  logic [ST_W-1:0]            irq_ack,
    output logic [ST_W-1:0]            irq_status,
    output logic                       irq
);

    logic    wr_vld, ovf_evt;
    tstamp_t wr_ent, rd_ent;

    tsr_capture #(.NUM_CH(NUM_CH)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ev_valid  (ev_valid),
        .ev_rising (ev_rising),
        .ev_coarse (ev_coarse),
        .ev_fine   (ev_fine),
        .wr_vld    (wr_vld),
        .wr_ent    (wr_ent)
    );

    tsr_ring #(.DEPTH(DEPTH), .WRAP_W(WRAP_W)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .wr_vld     (wr_vld),
        .wr_ent     (wr_ent),
        .pop        (rd_pop),
        .rd_valid   (rd_valid),
        .rd_data    (rd_ent),
        .unread_cnt (unread_cnt),
        .wr_ptr     (wr_ptr),
        .wrap_cnt   (wrap_cnt),
        .ovf_evt    (ovf_evt)
    );

    tsr_irq #(.CW(CW), .TMO_W(TMO_W)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .unread_cnt  (unread_cnt),
        .cfg_cnt_en  (cfg_cnt_en),
        .cfg_tmo_en  (cfg_tmo_en),
        .cfg_cnt_thr (cfg_cnt_thr),
        .cfg_tmo     (cfg_tmo),
        .irq_ack     (irq_ack),
        .ovf_evt     (ovf_evt),
        .irq_status  (irq_status),
        .irq         (irq)
    );

    assign rd_data = rd_ent;

endmodule

// File: rtl/tstamp_ring_chk.sv
module tstamp_ring_chk #(
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] unread_cnt,
    input logic [CW-1:0] cfg_cnt_thr,
    input logic [AW-1:0] wr_ptr,
    input logic          rd_valid,
    input logic [2:0]    irq_status,
    input logic [2:0]    irq_ack
);

    // R5: occupancy never exceeds the ring depth
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(unread_cnt) <= DEPTH);

    // R3: at most one entry is added per cycle
    a_r3_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
        int'(unread_cnt) <= int'($past(unread_cnt)) + 1);

    // R6: the write pointer only ever steps by one
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_ptr) |-> wr_ptr == AW'($past(wr_ptr) + 1'b1));

    // R4: returned data always follows a non-empty ring
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(unread_cnt) != '0);

    // R7: count status rises only when the threshold was met
    a_r7_cnt_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status[0]) |-> ($past(cfg_cnt_thr) != '0) && ($past(unread_cnt) >= $past(cfg_cnt_thr)));

    // R8: timeout status rises only while entries were waiting
    a_r8_tmo_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status[1]) |-> $past(unread_cnt) != '0);

    // R9: overflow stays set until acknowledged
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_status[2]) && !$past(irq_ack[2])) |-> irq_status[2]);

endmodule

bind tstamp_ring tstamp_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .unread_cnt  (unread_cnt),
    .cfg_cnt_thr (cfg_cnt_thr),
    .wr_ptr      (wr_ptr),
    .rd_valid    (rd_valid),
    .irq_status  (irq_status),
    .irq_ack     (irq_ack)
);

// File: tb/tb_tstamp_ring.sv
module tb_tstamp_ring;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 5;
    localparam int DEP   = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [4:0]   ev_valid = '0;
    logic [4:0]   ev_rising = '0;
    logic [159:0] ev_coarse = '0;
    logic [84:0]  ev_fine = '0;
    logic         rd_pop = 1'b0;
    logic         rd_valid;
    logic [52:0]  rd_data;
    logic [8:0]   unread_cnt;
    logic [7:0]   wr_ptr;
    logic [15:0]  wrap_cnt;
    logic         cfg_cnt_en = 1'b0;
    logic         cfg_tmo_en = 1'b0;
    logic [8:0]   cfg_cnt_thr = '0;
    logic [15:0]  cfg_tmo = '0;
    logic [2:0]   irq_ack = '0;
    logic [2:0]   irq_status;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tstamp_ring dut (
        .clk(clk), .rst(rst), .en(en), .ev_valid(ev_valid), .ev_rising(ev_rising),
        .ev_coarse(ev_coarse), .ev_fine(ev_fine), .rd_pop(rd_pop), .rd_valid(rd_valid),
        .rd_data(rd_data), .unread_cnt(unread_cnt), .wr_ptr(wr_ptr), .wrap_cnt(wrap_cnt),
        .cfg_cnt_en(cfg_cnt_en), .cfg_tmo_en(cfg_tmo_en), .cfg_cnt_thr(cfg_cnt_thr),
        .cfg_tmo(cfg_tmo), .irq_ack(irq_ack), .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_slot [NCH];
    logic [52:0] m_sent [NCH];
    logic [52:0] m_q [$];
    int          m_wp, m_wrap, m_timer;
    bit [2:0]    m_st;
    bit          m_rv;
    logic [52:0] m_rd;

    always @(posedge clk) begin
        int oc, g;
        bit fc, ft, pok, ovf;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin m_slot[i] = 1'b0; m_sent[i] = '0; end
            m_q.delete();
            m_wp = 0; m_wrap = 0; m_timer = 0; m_st = '0; m_rv = 1'b0; m_rd = '0;
        end else begin
            oc = m_q.size();
            g = -1;
            for (int i = 0; i < NCH; i++) if (m_slot[i] && g < 0) g = i;
            fc = cfg_cnt_en && cfg_cnt_thr != 0 && oc >= int'(cfg_cnt_thr);
            ft = cfg_tmo_en && cfg_tmo != 0 && oc != 0 && m_timer >= int'(cfg_tmo);
            m_timer = (oc == 0 || fc || ft) ? 0 : (m_timer + 1) % 65536;
            pok = rd_pop && oc != 0;
            m_rv = pok;
            if (pok) begin m_rd = m_q[0]; void'(m_q.pop_front()); end
            ovf = 1'b0;
            if (g >= 0) begin
                if (m_q.size() == DEP) begin void'(m_q.pop_front()); ovf = 1'b1; end
                m_q.push_back(m_sent[g]);
                if (m_wp == DEP - 1) m_wrap++;
                m_wp = (m_wp + 1) % DEP;
                m_slot[g] = 1'b0;
            end
            m_st = (m_st & ~irq_ack) | {ovf, ft, fc};
            for (int i = 0; i < NCH; i++) begin
                if (en && ev_valid[i] && !m_slot[i]) begin
                    m_slot[i] = 1'b1;
                    m_sent[i] = {ev_coarse[i*32 +: 32], ev_fine[i*17 +: 17], 3'(i), ev_rising[i]};
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(unread_cnt == 9'(m_q.size()), "R3 unread_cnt", 64'(unread_cnt), 64'(m_q.size()));
            chk(wr_ptr == 8'(m_wp), "R6 wr_ptr", 64'(wr_ptr), 64'(m_wp));
            chk(wrap_cnt == 16'(m_wrap), "R6 wrap_cnt", 64'(wrap_cnt), 64'(m_wrap));
            chk(irq_status[0] == m_st[0], "R7 status count bit", 64'(irq_status), 64'(m_st));
            chk(irq_status[1] == m_st[1], "R8 status timeout bit", 64'(irq_status), 64'(m_st));
            chk(irq_status[2] == m_st[2], "R5 status overflow bit", 64'(irq_status), 64'(m_st));
            chk(irq == (m_st[0] | m_st[1]), "R10 irq", 64'(irq), 64'(m_st[0] | m_st[1]));
            chk(rd_valid == m_rv, "R4 rd_valid", 64'(rd_valid), 64'(m_rv));
            if (m_rv) chk(rd_data == m_rd, "R2 rd_data", 64'(rd_data), 64'(m_rd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_ev(input int ch, input bit rising, input logic [31:0] c, input logic [16:0] f);
        ev_valid[ch] = 1'b1;
        ev_rising[ch] = rising;
        ev_coarse[ch*32 +: 32] = c;
        ev_fine[ch*17 +: 17] = f;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(unread_cnt == 0 && wr_ptr == 0 && wrap_cnt == 0 && irq_status == 0 && !irq && !rd_valid && rd_data == 0,
            "R10 reset outputs", 64'(unread_cnt), 64'd0);

        // R1: disabled channels ignore events
        for (int i = 0; i < NCH; i++) set_ev(i, 1'b1, 32'(100 + i), 17'(i));
        cycles(4);
        ev_valid = '0;
        cycles(3);
        chk(unread_cnt == 0, "R1 unread while disabled", 64'(unread_cnt), 64'd0);
        chk(wr_ptr == 0, "R1 wr_ptr while disabled", 64'(wr_ptr), 64'd0);

        // R3/R2: simultaneous events on channels 4, 0, 2 -> stored 0, 2, 4
        en = 1'b1;
        set_ev(4, 1'b0, 32'h4444_0004, 17'h1_0004);
        set_ev(0, 1'b1, 32'h0000_0A00, 17'h0_0A00);
        set_ev(2, 1'b0, 32'h2222_0002, 17'h0_0222);
        @(negedge clk);
        ev_valid = '0;
        cycles(5);
        chk(unread_cnt == 3, "R3 three entries stored", 64'(unread_cnt), 64'd3);
        pop_one();
        chk(rd_data[3:1] == 3'd0 && rd_data[0] == 1'b1, "R3 first channel 0 rising", 64'(rd_data[3:0]), 64'h1);
        chk(rd_data[52:21] == 32'h0000_0A00, "R2 coarse field", 64'(rd_data[52:21]), 64'h0A00);
        pop_one();
        chk(rd_data[3:1] == 3'd2 && rd_data[0] == 1'b0, "R3 second channel 2 falling", 64'(rd_data[3:0]), 64'h4);
        pop_one();
        chk(rd_data[3:1] == 3'd4 && rd_data[20:4] == 17'h1_0004, "R2 third channel 4 fine", 64'(rd_data[20:0]), 64'h1_0004_8);
        @(negedge clk);

        // R8: timeout interrupt with one pending entry
        cfg_tmo = 16'd20;
        cfg_tmo_en = 1'b1;
        set_ev(1, 1'b1, 32'd777, 17'd7);
        @(negedge clk);
        ev_valid = '0;
        cycles(10);
        chk(irq_status[1] == 1'b0, "R8 no timeout yet", 64'(irq_status), 64'd0);
        cycles(20);
        chk(irq_status[1] == 1'b1 && irq, "R8 timeout fired", 64'(irq_status), 64'd2);
        pop_one();
        irq_ack = 3'b010;
        @(negedge clk);
        irq_ack = '0;
        cycles(30);
        chk(irq_status[1] == 1'b0 && !irq, "R9 timeout acknowledged and quiet when empty", 64'(irq_status), 64'd0);
        cfg_tmo_en = 1'b0;

        // R7: count threshold of 8
        cfg_cnt_thr = 9'd8;
        cfg_cnt_en = 1'b1;
        for (int k = 0; k < 7; k++) begin set_ev(3, k[0], 32'(2000 + k), 17'(k)); @(negedge clk); end
        ev_valid = '0;
        cycles(4);
        chk(irq_status[0] == 1'b0, "R7 below threshold", 64'(irq_status), 64'd0);
        set_ev(3, 1'b1, 32'd2007, 17'd7);
        @(negedge clk);
        ev_valid = '0;
        cycles(3);
        chk(irq_status[0] == 1'b1 && irq, "R7 threshold reached", 64'(irq_status), 64'd1);
        irq_ack = 3'b001;               // R9 set wins while condition holds
        @(negedge clk);
        irq_ack = '0;
        @(negedge clk);
        chk(irq_status[0] == 1'b1, "R9 set wins over clear", 64'(irq_status), 64'd1);
        for (int k = 0; k < 8; k++) pop_one();
        irq_ack = 3'b001;
        @(negedge clk);
        irq_ack = '0;
        cycles(2);
        chk(irq_status[0] == 1'b0, "R9 count acknowledged", 64'(irq_status), 64'd0);
        cfg_cnt_en = 1'b0;

        // R5: overflow by streaming 300 events on channel 1
        for (int k = 0; k < 300; k++) begin set_ev(1, 1'b1, 32'(1000 + k), 17'(k)); @(negedge clk); end
        ev_valid = '0;
        cycles(3);
        chk(unread_cnt == 9'd256, "R5 ring stays full", 64'(unread_cnt), 64'd256);
        chk(irq_status[2] == 1'b1 && !irq, "R5 overflow set without irq", 64'(irq_status), 64'd4);
        chk(wrap_cnt >= 16'd1, "R6 wrap counted", 64'(wrap_cnt), 64'd1);
        pop_one();
        chk(rd_data[52:21] == 32'd1044, "R5 oldest survivor", 64'(rd_data[52:21]), 64'd1044);
        irq_ack = 3'b100;
        @(negedge clk);
        irq_ack = '0;
        @(negedge clk);
        chk(irq_status[2] == 1'b0, "R9 overflow acknowledged", 64'(irq_status), 64'd0);
        for (int k = 0; k < 255; k++) pop_one();
        chk(unread_cnt == 0, "R4 drained", 64'(unread_cnt), 64'd0);
        pop_one();
        chk(rd_valid == 1'b0, "R4 pop on empty ignored", 64'(rd_valid), 64'd0);
        cycles(3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule